// File: doc/BRIEF.md
# Proportional Text Run Layout Engine

This block lays out a run of 8-bit character codes for a proportional font. Two codes are packed in each 16-bit word of a word-addressed memory. For every character the engine looks up the code's 2-bit class flags, its output width in bits and its width in fine, device-independent units. It then advances two horizontal positions: a fine position, checked against a margin, and an output bit position. In display mode it hands each glyph to a separate transfer unit through a start/done handshake and waits for that unit to finish.

Software, or a sequencer, pulses `start` with the starting index, the last index, both positions, a pad count, a margin, a space value, a mode and five table base addresses. The run ends in one of three ways: the index passes the last index, a character would cross the margin, or a stop character is reached. When it ends, the engine pulses `done` with a result code. It also publishes its index, bit position, fine position and count, so that a later `start` can pick up the run where it stopped. Only one memory request is outstanding at any time, and the engine waits for `mem_valid` before it uses the returned data. The same rule applies to writes.

Top module: `text_run_engine`

## Requirements
- R1: Each character step begins with a test of the 16-bit difference last − index, read as a signed value. If that value is negative, the run ends with result 0 and the published state is not changed any further.
- R2: The character at index i is a byte of text word `text_base + (i>>1)`. An even i selects bits [15:8] and an odd i selects bits [7:0].
- R3: The flags of code c are bits [2k+1:2k] of word `flag_base + (c>>3)`, where k = c[2:0]. Bit 2k marks a stop character and bit 2k+1 marks a pad character.
- R4: A stop character ends the run with result 2. This happens before any width read, and the index, bit position, fine position and count keep the values they had before that character.
- R5: The fine width of code c is word `entry_base + 2c + 1`. If fine position + width, taken as an unsigned sum with no wrap, is greater than `margin`, the run ends with result 1 and the fine position is not changed. Otherwise the fine position becomes the sum.
- R6: The bit width of code c is a byte of word `width_base + (c>>1)`, selected as in R2 but by the parity of c. After the character, the bit position advances by this width.
- R7: The mode is 0 for display, 1 for format and 2 for resolve. In resolve mode the engine writes the current bit position to word `coord_base + index` before it reads the character.
- R8: Only display mode raises `xfer_start`, for one cycle. The step does not complete until `xfer_done` is seen. While `xfer_start` is high, `xfer_bitpos` holds the bit position before the glyph and `xfer_width` holds its bit width.
- R9: For a pad character in any mode other than format, the count is incremented and the bit position also advances by `space`. If the incremented count, read as signed, is ≤ 0, the bit position advances by one more unit. In format mode a pad character is treated like any other character.
- R10: `busy` is high from the cycle after `start` until `done`. `done` is a one-cycle pulse carrying a result code of 0, 1 or 2. No memory request or transfer start occurs while the engine is idle.
- R11: A new `start` loads index, bit position, fine position and count from the inputs. Restarting from the published values of an earlier run therefore continues that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| mode | input | 2 | 0 display, 1 format, 2 resolve |
| idx_in | input | 16 | Starting character index |
| last_idx | input | 16 | Index of the final character |
| bitpos_in | input | 16 | Starting bit position |
| finepos_in | input | 16 | Starting fine position |
| count_in | input | 16 | Starting pad count (signed) |
| margin | input | 16 | Unsigned fine-unit margin |
| space | input | 16 | Extra bits per pad character |
| text_base | input | AW | Base of packed text words |
| flag_base | input | AW | Base of flag table |
| width_base | input | AW | Base of bit-width table |
| entry_base | input | AW | Base of 2-word character entries |
| coord_base | input | AW | Base of coordinate array |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_valid | input | 1 | Read data valid / write accepted |
| mem_rdata | input | 16 | Read data |
| xfer_start | output | 1 | Start glyph transfer |
| xfer_done | input | 1 | Glyph transfer finished |
| xfer_entry | output | 16 | First word of the character entry |
| xfer_width | output | 8 | Glyph bit width |
| xfer_bitpos | output | 16 | Destination bit position |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| result | output | 2 | 0 last index, 1 margin, 2 stop |
| idx_out | output | 16 | Published index |
| bitpos_out | output | 16 | Published bit position |
| finepos_out | output | 16 | Published fine position |
| count_out | output | 16 | Published pad count |

## Verification
No result appears at a fixed cycle count, because every character costs one memory round trip per lookup, plus a transfer wait in display mode. For that reason the bench waits for the `done` pulse, sampling on falling edges, and only then compares the published state and result against a reference walk of the same tables. The memory model answers two edges after each request. The transfer model finishes three cycles after `xfer_start`, and it latches the bit position and width on that start cycle. The coordinate array and the transfer count are read back once the run has ended, which keeps every comparison clear of the cycle in which a value changes.

// File: rtl/text_run_engine.sv
module text_run_engine #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic [15:0]   idx_in,
  input  logic [15:0]   last_idx,
  input  logic [15:0]   bitpos_in,
  input  logic [15:0]   finepos_in,
  input  logic [15:0]   count_in,
  input  logic [15:0]   margin,
  input  logic [15:0]   space,
  input  logic [AW-1:0] text_base,
  input  logic [AW-1:0] flag_base,
  input  logic [AW-1:0] width_base,
  input  logic [AW-1:0] entry_base,
  input  logic [AW-1:0] coord_base,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic          mem_valid,
  input  logic [15:0]   mem_rdata,
  output logic          xfer_start,
  input  logic          xfer_done,
  output logic [15:0]   xfer_entry,
  output logic [7:0]    xfer_width,
  output logic [15:0]   xfer_bitpos,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic [15:0]   idx_out,
  output logic [15:0]   bitpos_out,
  output logic [15:0]   finepos_out,
  output logic [15:0]   count_out
);

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_COORD, S_TEXT, S_FLAG, S_WID, S_ENT0, S_ENT1, S_XFER, S_ADV
  } state_t;

  state_t        st;
  logic [1:0]    mode_q;
  logic [15:0]   last_q, idx_q, bit_q, fine_q, cnt_q, newfine_q, entry_q, wdata_q;
  logic [7:0]    ch_q, wb_q;
  logic [1:0]    flg_q;
  logic          req_q, we_q, xst_q, done_q;
  logic [1:0]    res_q;
  logic [AW-1:0] addr_q;

  logic [15:0] diff, fshift, cnt_inc, bit_adv, pad_add;
  logic [16:0] fine_sum;
  logic [7:0]  rd_byte_idx, rd_byte_ch;
  logic        pad_now;

  assign diff        = last_q - idx_q;
  assign fshift      = mem_rdata >> {ch_q[2:0], 1'b0};
  assign fine_sum    = {1'b0, fine_q} + {1'b0, mem_rdata};
  assign rd_byte_idx = idx_q[0] ? mem_rdata[7:0] : mem_rdata[15:8];
  assign rd_byte_ch  = ch_q[0]  ? mem_rdata[7:0] : mem_rdata[15:8];
  assign cnt_inc     = cnt_q + 16'd1;
  assign pad_now     = flg_q[1] && (mode_q != 2'd1);
  assign pad_add     = pad_now ? space + {15'd0, ($signed(cnt_inc) <= 0)} : 16'd0;
  assign bit_adv     = bit_q + {8'd0, wb_q} + pad_add;

  assign mem_req     = req_q;
  assign mem_we      = we_q;
  assign mem_addr    = addr_q;
  assign mem_wdata   = wdata_q;
  assign xfer_start  = xst_q;
  assign xfer_entry  = entry_q;
  assign xfer_width  = wb_q;
  assign xfer_bitpos = bit_q;
  assign busy        = (st != S_IDLE);
  assign done        = done_q;
  assign result      = res_q;
  assign idx_out     = idx_q;
  assign bitpos_out  = bit_q;
  assign finepos_out = fine_q;
  assign count_out   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; mode_q <= '0; last_q <= '0; idx_q <= '0; bit_q <= '0;
      fine_q <= '0; cnt_q <= '0; newfine_q <= '0; entry_q <= '0; wdata_q <= '0;
      ch_q <= '0; wb_q <= '0; flg_q <= '0; req_q <= 1'b0; we_q <= 1'b0;
      xst_q <= 1'b0; done_q <= 1'b0; res_q <= '0; addr_q <= '0;
    end else begin
      req_q  <= 1'b0;
      xst_q  <= 1'b0;
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mode_q <= mode; last_q <= last_idx; idx_q <= idx_in;
          bit_q <= bitpos_in; fine_q <= finepos_in; cnt_q <= count_in;
          st <= S_CHECK;
        end
        S_CHECK: begin
          if ($signed(diff) < 0) begin
            res_q <= 2'd0; done_q <= 1'b1; st <= S_IDLE;
          end else if (mode_q == 2'd2) begin
            req_q <= 1'b1; we_q <= 1'b1; wdata_q <= bit_q;
            addr_q <= coord_base + AW'(idx_q); st <= S_COORD;
          end else begin
            req_q <= 1'b1; we_q <= 1'b0;
            addr_q <= text_base + AW'(idx_q >> 1); st <= S_TEXT;
          end
        end
        S_COORD: if (mem_valid) begin
          req_q <= 1'b1; we_q <= 1'b0;
          addr_q <= text_base + AW'(idx_q >> 1); st <= S_TEXT;
        end
        S_TEXT: if (mem_valid) begin
          ch_q <= rd_byte_idx; req_q <= 1'b1;
          addr_q <= flag_base + AW'(rd_byte_idx >> 3); st <= S_FLAG;
        end
        S_FLAG: if (mem_valid) begin
          flg_q <= fshift[1:0];
          if (fshift[0]) begin
            res_q <= 2'd2; done_q <= 1'b1; st <= S_IDLE;
          end else begin
            req_q <= 1'b1; addr_q <= width_base + AW'(ch_q >> 1); st <= S_WID;
          end
        end
        S_WID: if (mem_valid) begin
          wb_q <= rd_byte_ch; req_q <= 1'b1;
          addr_q <= entry_base + AW'({ch_q, 1'b0}); st <= S_ENT0;
        end
        S_ENT0: if (mem_valid) begin
          entry_q <= mem_rdata; req_q <= 1'b1;
          addr_q <= entry_base + AW'({ch_q, 1'b1}); st <= S_ENT1;
        end
        S_ENT1: if (mem_valid) begin
          if (fine_sum > {1'b0, margin}) begin
            res_q <= 2'd1; done_q <= 1'b1; st <= S_IDLE;
          end else begin
            newfine_q <= fine_sum[15:0];
            if (mode_q == 2'd0) begin
              xst_q <= 1'b1; st <= S_XFER;
            end else st <= S_ADV;
          end
        end
        S_XFER: if (xfer_done) st <= S_ADV;
        S_ADV: begin
          bit_q <= bit_adv;
          if (pad_now) cnt_q <= cnt_inc;
          fine_q <= newfine_q;
          idx_q <= idx_q + 16'd1;
          st <= S_CHECK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !xfer_start));
  assert_result_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result != 2'd3));
  assert_end_past_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd0) |-> ($signed(last_q - idx_out) < 0));
  assert_margin_keeps_fine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd1) |-> $stable(finepos_out));
  assert_stop_keeps_bitpos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == 2'd2) |-> ($stable(bitpos_out) && $stable(count_out)));
  assert_coord_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == bitpos_out && mode_q == 2'd2));
  assert_xfer_display_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (mode_q == 2'd0 && busy));

endmodule

// File: tb/test_text_run_engine.sv
module test_text_run_engine;
  localparam int TB = 16'h000, FB = 16'h100, WB = 16'h200, EB = 16'h300, CB = 16'h080;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] mode = '0;
  logic [15:0] idx_in = '0, last_idx = '0, bitpos_in = '0, finepos_in = '0, count_in = '0;
  logic [15:0] margin = '0, space = '0;
  logic [15:0] text_base = 16'(TB), flag_base = 16'(FB), width_base = 16'(WB);
  logic [15:0] entry_base = 16'(EB), coord_base = 16'(CB);
  logic mem_req, mem_we, mem_valid = 1'b0, xfer_start, xfer_done = 1'b0;
  logic [15:0] mem_addr, mem_wdata, mem_rdata = '0, xfer_entry, xfer_bitpos;
  logic [7:0] xfer_width;
  logic busy, done;
  logic [1:0] result;
  logic [15:0] idx_out, bitpos_out, finepos_out, count_out;

  logic [15:0] mem [0:2047];
  logic [15:0] cmem [0:2047];
  logic [15:0] ec [0:63];
  logic pend = 1'b0, pw = 1'b0;
  logic [10:0] pa = '0;
  logic [15:0] pwd = '0;
  int xwait = 0, nxfer = 0;
  logic [15:0] last_xbit = '0;
  logic [7:0] last_xw = '0;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  text_run_engine #(.AW(16)) i_text_run_engine (.*);

  always @(negedge clk) begin
    mem_valid <= 1'b0;
    if (pend) begin
      mem_valid <= 1'b1; mem_rdata <= mem[pa];
      if (pw) cmem[pa] <= pwd;
      pend <= 1'b0;
    end else if (mem_req) begin
      pend <= 1'b1; pa <= mem_addr[10:0]; pw <= mem_we; pwd <= mem_wdata;
    end
  end

  always @(negedge clk) begin
    xfer_done <= 1'b0;
    if (xwait != 0) begin
      xwait <= xwait - 1;
      if (xwait == 1) xfer_done <= 1'b1;
    end else if (xfer_start) begin
      xwait <= 3; nxfer <= nxfer + 1; last_xbit <= xfer_bitpos; last_xw <= xfer_width;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bsel(input logic [15:0] w, input logic odd);
    return odd ? w[7:0] : w[15:8];
  endfunction

  task automatic put_text(input string s);
    for (int k = 0; k < s.len(); k++) begin
      if (k[0]) mem[TB + k/2][7:0] = s[k];
      else mem[TB + k/2][15:8] = s[k];
    end
  endtask

  task automatic ref_run(input logic [1:0] md, input logic [15:0] i0, lst, b0, f0, c0, mg, sp,
                         output logic [1:0] r, output logic [15:0] i, b, f, c,
                         output int nx, output logic [15:0] lxb);
    logic [7:0] ch, wb;
    logic [15:0] fl, fw, d;
    i = i0; b = b0; f = f0; c = c0; nx = 0; lxb = 0; r = 0;
    for (int g = 0; g < 64; g++) begin
      d = lst - i;
      if ($signed(d) < 0) begin r = 0; return; end
      if (md == 2'd2) ec[i[5:0]] = b;
      ch = bsel(mem[TB + 32'(i >> 1)], i[0]);
      fl = mem[FB + 32'(ch >> 3)] >> (2 * ch[2:0]);
      if (fl[0]) begin r = 2; return; end
      wb = bsel(mem[WB + 32'(ch >> 1)], ch[0]);
      fw = mem[EB + 2 * 32'(ch) + 1];
      if ({1'b0, f} + {1'b0, fw} > {1'b0, mg}) begin r = 1; return; end
      if (md == 2'd0) begin nx++; lxb = b; end
      b = b + {8'd0, wb};
      if (fl[1] && md != 2'd1) begin
        c = c + 1;
        b = b + sp + (($signed(c) <= 0) ? 16'd1 : 16'd0);
      end
      f = f + fw; i = i + 1;
    end
  endtask

  task automatic run_case(input string tag, input logic [1:0] md, input logic [15:0] i0, lst, b0, f0, c0, mg, sp);
    logic [1:0] er; logic [15:0] ei, eb, ef, ecn, lxb; int enx, x0, n;
    ref_run(md, i0, lst, b0, f0, c0, mg, sp, er, ei, eb, ef, ecn, enx, lxb);
    x0 = nxfer;
    @(negedge clk);
    mode = md; idx_in = i0; last_idx = lst; bitpos_in = b0; finepos_in = f0;
    count_in = c0; margin = mg; space = sp; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({tag, " busy"}, 32'(busy), 1);
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) begin chk({tag, " timeout"}, 0, 1); return; end
    chk({tag, " result"}, 32'(result), 32'(er));
    chk({tag, " index"}, 32'(idx_out), 32'(ei));
    chk({tag, " bitpos"}, 32'(bitpos_out), 32'(eb));
    chk({tag, " finepos"}, 32'(finepos_out), 32'(ef));
    chk({tag, " count"}, 32'(count_out), 32'(ecn));
    chk({tag, " transfers"}, 32'(nxfer - x0), 32'(enx));
    if (enx > 0) chk({tag, " xfer bitpos"}, 32'(last_xbit), 32'(lxb));
    @(negedge clk);
    chk({tag, " idle"}, 32'(busy), 0);
  endtask

  task automatic t_display;
    put_text("ABCD");
    run_case("R1 R2 R6 R8 display run", 2'd0, 16'd0, 16'd3, 16'd5, 16'd0, 16'd0, 16'hFFFF, 16'd4);
    chk("R8 xfer width of D", 32'(last_xw), 32'((8'h44 & 7) + 1));
  endtask

  task automatic t_odd_start;
    put_text("QRSTU");
    run_case("R2 odd start index", 2'd1, 16'd1, 16'd1, 16'd0, 16'd0, 16'd0, 16'hFFFF, 16'd0);
    chk("R2 bitpos from R", 32'(bitpos_out), 32'((8'h52 & 7) + 1));
  endtask

  task automatic t_stop;
    put_text("ABZC");
    run_case("R3 R4 stop char", 2'd0, 16'd0, 16'd3, 16'd0, 16'd0, 16'd0, 16'hFFFF, 16'd0);
    chk("R4 stop index", 32'(idx_out), 2);
  endtask

  task automatic t_margin;
    put_text("ABCD");
    run_case("R5 margin stop", 2'd1, 16'd0, 16'd3, 16'd0, 16'd100, 16'd0, 16'd124, 16'd0);
    chk("R5 margin index", 32'(idx_out), 2);
    run_case("R11 resume", 2'd1, idx_out, 16'd3, bitpos_out, finepos_out, count_out, 16'd200, 16'd0);
    chk("R11 resumed end index", 32'(idx_out), 4);
  endtask

  task automatic t_margin_edge;
    put_text("A");
    run_case("R5 equal margin passes", 2'd1, 16'd0, 16'd0, 16'd0, 16'hFFF0, 16'd0, 16'hFFFB, 16'd0);
    run_case("R5 unsigned no wrap", 2'd1, 16'd0, 16'd0, 16'd0, 16'hFFF8, 16'd0, 16'hFFFF, 16'd0);
  endtask

  task automatic t_pad;
    put_text("A   B");
    run_case("R9 pad display", 2'd0, 16'd0, 16'd4, 16'd0, 16'd0, 16'hFFFE, 16'hFFFF, 16'd7);
    chk("R9 count", 32'(count_out), 1);
    run_case("R9 pad ignored in format", 2'd1, 16'd0, 16'd4, 16'd0, 16'd0, 16'hFFFE, 16'hFFFF, 16'd7);
    chk("R9 format count", 32'(count_out), 32'hFFFE);
  endtask

  task automatic t_resolve;
    put_text("HI JZ");
    for (int k = 0; k < 64; k++) cmem[CB + k] = 16'hDEAD;
    run_case("R7 resolve", 2'd2, 16'd0, 16'd4, 16'd3, 16'd0, 16'd0, 16'hFFFF, 16'd2);
    for (int k = 0; k <= 4; k++) chk("R7 coord entry", 32'(cmem[CB + k]), 32'(ec[k]));
    chk("R7 coord beyond stop untouched", 32'(cmem[CB + 5]), 32'hDEAD);
  endtask

  task automatic t_empty;
    put_text("AB");
    run_case("R1 empty run", 2'd0, 16'd5, 16'd4, 16'd9, 16'd9, 16'd9, 16'hFFFF, 16'd0);
    chk("R1 empty index", 32'(idx_out), 5);
  endtask

  initial begin
    for (int a = 0; a < 2048; a++) begin mem[a] = 16'd0; cmem[a] = 16'd0; end
    for (int c = 0; c < 256; c++) begin
      if (c[0]) mem[WB + c/2][7:0] = 8'((c & 7) + 1);
      else mem[WB + c/2][15:8] = 8'((c & 7) + 1);
      mem[EB + 2*c] = 16'(c);
      mem[EB + 2*c + 1] = 16'(10 + (c & 15));
    end
    mem[FB + (8'h5A >> 3)][2*(8'h5A & 7)] = 1'b1;
    mem[FB + (8'h20 >> 3)][2*(8'h20 & 7) + 1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 reset busy", 32'(busy), 0);
    chk("R10 reset done", 32'(done), 0);
    chk("R10 reset req", 32'(mem_req), 0);
    chk("R10 reset xfer", 32'(xfer_start), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10 idle ignores no start", 32'(busy), 0);
    t_display;
    t_odd_start;
    t_stop;
    t_margin;
    t_margin_edge;
    t_pad;
    t_resolve;
    t_empty;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule